// File: doc/BRIEF.md
# Two-Wire DAC Control Slave

This block is the digital front end of a small voltage-output DAC. It listens on a two-wire (I2C-compatible) bus as a receive-only slave. A fast system clock samples the bus lines. Each line passes through a synchronizer and a glitch filter before any edge is detected.

A transaction has two bytes. The first byte carries a 7-bit address, set by a base value and a 2-bit strap. The last bit of the first byte is a power-down request, not a read/write flag. The second byte carries the DAC code. The new code and power mode take effect only when a STOP condition closes a complete, acknowledged two-byte transfer. The block then raises a one-cycle update strobe. An open-drain pull-down enable drives SDA low only during acknowledge slots.

Top module: `twdac_slave`

## Requirements
- R1: After reset, `dac_code` is 0, `shutdown` is 0, `update` is 0 and `sda_pull` is 0.
- R2: The slave matches a 7-bit address equal to 0x30 plus `addr_sel`. On the wire these are the first bytes 0x60, 0x62, 0x64 and 0x66, with bit 0 as the power bit. On a match the slave pulls SDA low during the ninth clock, whatever the value of bit 0.
- R3: A non-matching address, including the general call address 0x00, is not acknowledged and changes nothing.
- R4: A STOP or a repeated START straight after the address byte leaves `dac_code` and `shutdown` unchanged, and no update strobe occurs.
- R5: With power bit 0, the second byte is taken MSB first, and the slave acknowledges it in the ninth clock. A following STOP sets `dac_code` to the byte, clears `shutdown`, and raises `update` for exactly one cycle.
- R6: With power bit 1, the slave never drives SDA during the second byte or its ninth clock, so the master reads 0xFF and a released ninth bit. A following STOP sets `shutdown` to 1 and leaves `dac_code` unchanged.
- R7: A repeated START after the acknowledged second byte discards the pending update. The transaction that follows is handled normally.
- R8: A third byte after the second byte, before STOP, is not acknowledged. The pending update is dropped, and the STOP that follows changes nothing.
- R9: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect on the received data.
- R10: `dac_code` and `shutdown` change only in a cycle in which `update` is high.
- R11: `sda_pull` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 2 | Address strap added to the base address |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | High to pull SDA low (open-drain enable) |
| dac_code | output | 8 | Committed DAC code: 6 data bits and 2 sub-bits |
| shutdown | output | 1 | Committed power-down state |
| update | output | 1 | One-cycle strobe when a commit happens |

## Verification
The assertions check, on every cycle, the properties that hold at all times. The code and power state move only with the strobe. The strobe never lasts two cycles. A shutdown commit leaves the code alone. The pull-down toggles only while the filtered clock is low. The bench alone can show the sequence-dependent behaviour: which addresses are acknowledged, that an address-only transfer, a repeated START or a third byte discards the update, that a read in shutdown returns all ones, and that short pulses on either line are rejected.

// File: rtl/twl_pkg.sv
package twl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_DATA,
      ST_DACK,
      ST_WSTOP,
      ST_SKIP
   } twl_state_e;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned ADDR7_W = 7;
endpackage

// File: rtl/twl_deglitch.sv
module twl_deglitch #(
   parameter int unsigned FILT_LEN = 4,
   parameter bit          RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   logic s1, s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= RST_VAL;
         s2 <= RST_VAL;
      end else begin
         s1 <= raw;
         s2 <= s1;
      end
   end

   generate
      if (FILT_LEN == 0) begin : g_bypass
         assign clean = s2;
      end else begin : g_filter
         localparam int unsigned CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
         localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_LEN - 1);
         logic [CNT_W-1:0] cnt;
         logic             held;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               held <= RST_VAL;
            end else if (s2 == held) begin
               cnt <= '0;
            end else if (cnt == CNT_TOP) begin
               cnt  <= '0;
               held <= s2;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign clean = held;
      end
   endgenerate
endmodule

// File: rtl/twl_cond_detect.sv
module twl_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_c,
   input  logic sda_c,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_c;
         sda_p <= sda_c;
      end
   end

   assign scl_rise = scl_c & ~scl_p;
   assign scl_fall = ~scl_c & scl_p;
   assign start_c  = scl_c & scl_p & sda_p & ~sda_c;
   assign stop_c   = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/twl_dac_ctrl.sv
module twl_dac_ctrl
   import twl_pkg::*;
#(
   parameter int unsigned   ADDR_SEL_W = 2,
   parameter logic [6:0]    BASE7      = 7'h30
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_SEL_W-1:0] addr_sel,
   input  logic                  sda_c,
   input  logic                  scl_rise,
   input  logic                  scl_fall,
   input  logic                  start_c,
   input  logic                  stop_c,
   output logic                  sda_pull,
   output logic [BYTE_W-1:0]     dac_code,
   output logic                  shutdown,
   output logic                  update
);
   localparam logic [3:0] LAST_BIT = 4'd8;

   twl_state_e         st;
   logic [BYTE_W-1:0]  sh;
   logic [BYTE_W-1:0]  pend;
   logic [3:0]         cnt;
   logic               pd;
   logic [ADDR7_W-1:0] my_addr;

   assign my_addr = BASE7 | {{(ADDR7_W-ADDR_SEL_W){1'b0}}, addr_sel};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sh       <= '0;
         pend     <= '0;
         cnt      <= '0;
         pd       <= 1'b0;
         sda_pull <= 1'b0;
         dac_code <= '0;
         shutdown <= 1'b0;
         update   <= 1'b0;
      end else begin
         update <= 1'b0;
         if (start_c) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            sda_pull <= 1'b0;
         end else if (stop_c) begin
            sda_pull <= 1'b0;
            st       <= ST_IDLE;
            if (st == ST_WSTOP) begin
               update   <= 1'b1;
               shutdown <= pd;
               if (!pd) dac_code <= pend;
            end
         end else begin
            unique case (st)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_c};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     cnt <= '0;
                     if (sh[BYTE_W-1:1] == my_addr) begin
                        pd       <= sh[0];
                        sda_pull <= 1'b1;
                        st       <= ST_AACK;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     cnt      <= '0;
                     st       <= ST_DATA;
                  end
               end
               ST_DATA: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_c};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     pend     <= sh;
                     sda_pull <= ~pd;
                     st       <= ST_DACK;
                  end
               end
               ST_DACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     st       <= ST_WSTOP;
                  end
               end
               ST_WSTOP: begin
                  if (scl_fall) st <= ST_SKIP;
               end
               default: begin
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/twdac_slave.sv
module twdac_slave #(
   parameter int unsigned FILT_LEN   = 4,
   parameter int unsigned ADDR_SEL_W = 2,
   parameter logic [6:0]  BASE7      = 7'h30
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_SEL_W-1:0] addr_sel,
   input  logic                  scl_in,
   input  logic                  sda_in,
   output logic                  sda_pull,
   output logic [7:0]            dac_code,
   output logic                  shutdown,
   output logic                  update
);
   localparam int unsigned N_LINES = 2;
   localparam logic [6:0] SEL_MASK = 7'((1 << ADDR_SEL_W) - 1);

   generate
      if (FILT_LEN > 64) begin : g_bad_filt
         $error("FILT_LEN must not exceed 64");
      end
      if (ADDR_SEL_W < 1 || ADDR_SEL_W > 3) begin : g_bad_sel
         $error("ADDR_SEL_W must be 1 to 3");
      end
      if ((BASE7 & SEL_MASK) != 7'd0) begin : g_bad_base
         $error("BASE7 low bits must be zero under the strap");
      end
   endgenerate

   logic [N_LINES-1:0] raw_vec;
   logic [N_LINES-1:0] clean_vec;
   logic scl_clean, sda_clean;
   logic scl_rise, scl_fall, start_c, stop_c;

   assign raw_vec = {sda_in, scl_in};

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         twl_deglitch #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_vec[i]),
            .clean (clean_vec[i])
         );
      end
   endgenerate

   assign scl_clean = clean_vec[0];
   assign sda_clean = clean_vec[1];

   twl_cond_detect u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_c    (scl_clean),
      .sda_c    (sda_clean),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_c  (start_c),
      .stop_c   (stop_c)
   );

   twl_dac_ctrl #(.ADDR_SEL_W(ADDR_SEL_W), .BASE7(BASE7)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_sel (addr_sel),
      .sda_c    (sda_clean),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_c  (start_c),
      .stop_c   (stop_c),
      .sda_pull (sda_pull),
      .dac_code (dac_code),
      .shutdown (shutdown),
      .update   (update)
   );
endmodule

// File: rtl/twdac_slave_chk.sv
module twdac_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_f,
   input logic       sda_pull,
   input logic [7:0] dac_code,
   input logic       shutdown,
   input logic       update
);
   AST_CODE_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_code) |-> update); // R10
   AST_SHDN_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shutdown) |-> update); // R10
   AST_UPDATE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      update |=> !update); // R5
   AST_SHDN_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (update && shutdown) |-> $stable(dac_code)); // R6
   AST_PULL_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_f); // R11
   AST_PULL_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull) |-> !scl_f); // R11
endmodule

bind twdac_slave twdac_slave_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_f    (scl_clean),
   .sda_pull (sda_pull),
   .dac_code (dac_code),
   .shutdown (shutdown),
   .update   (update)
);

// File: tb/tb_twdac_slave.sv
module tb_twdac_slave;
   localparam int Q = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr_sel = 2'd0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_line;
   logic       sda_pull;
   logic [7:0] dac_code;
   logic       shutdown;
   logic       update;

   int n_chk = 0;
   int n_bad = 0;
   int upd_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign sda_line = m_sda & ~sda_pull;

   twdac_slave dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_sel (addr_sel),
      .scl_in   (m_scl),
      .sda_in   (sda_line),
      .sda_pull (sda_pull),
      .dac_code (dac_code),
      .shutdown (shutdown),
      .update   (update)
   );

   always @(negedge clk) if (rst_n && update) upd_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic do_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(2*Q);
      tick(20);
   endtask

   // gl: 0 none, 1 short SCL pulse in low phase, 2 short SDA low pulse in high phase
   task automatic clk_bit(input bit b, input int gl, output bit seen);
      m_sda = b;
      if (gl == 1) begin
         tick(1); m_scl = 1'b1; tick(3); m_scl = 1'b0; tick(Q - 4 + Q);
      end else begin
         tick(Q);
      end
      m_scl = 1'b1;
      if (gl == 2) begin
         tick(2); m_sda = 1'b0; tick(3); m_sda = b; seen = sda_line; tick(2*Q - 5);
      end else begin
         tick(Q); seen = sda_line; tick(Q);
      end
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, input int gl_bit, input int gl, output bit acked);
      bit s;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], (i == gl_bit) ? gl : 0, s);
      clk_bit(1'b1, 0, s);
      acked = !s;
   endtask

   task automatic read_byte(output logic [7:0] v, output bit ninth);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, 0, s);
         v[i] = s;
      end
      clk_bit(1'b1, 0, s);
      ninth = s;
   endtask

   task automatic write_tx(input logic [6:0] a, input logic [7:0] d,
                           output bit ack1, output bit ack2);
      do_start();
      send_byte({a, 1'b0}, -1, 0, ack1);
      send_byte(d, -1, 0, ack2);
      do_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      bit a1, a2, nine;
      logic [7:0] rv;
      int u0;
      tick(4);
      // R1: reset values
      chk("R1 code", dac_code, 0);
      chk("R1 shutdown", shutdown, 0);
      chk("R1 update", update, 0);
      chk("R1 pull", sda_pull, 0);
      rst_n = 1'b1;
      tick(10);

      // R2 R5: every code, strap rotating
      for (int c = 0; c < 256; c++) begin
         addr_sel = 2'(c % 4);
         tick(2);
         u0 = upd_cnt;
         write_tx(7'h30 + 7'(c % 4), 8'(c), a1, a2);
         chk("R2 addr ack", a1, 1);
         chk("R5 data ack", a2, 1);
         chk("R5 code", dac_code, c);
         chk("R5 shutdown clear", shutdown, 0);
         chk("R5 one strobe", upd_cnt - u0, 1);
      end

      // R3 R4: all addresses, address byte then STOP
      addr_sel = 2'd1;
      tick(2);
      for (int a = 0; a < 128; a++) begin
         u0 = upd_cnt;
         do_start();
         send_byte({7'(a), 1'b0}, -1, 0, a1);
         do_stop();
         chk((a == 'h31) ? "R2 match ack" : "R3 no ack", a1, (a == 'h31) ? 1 : 0);
         chk("R4 code kept", dac_code, 255);
         chk("R4 no strobe", upd_cnt - u0, 0);
      end

      // R2 R4: power bit 1, address then repeated START then STOP
      u0 = upd_cnt;
      do_start();
      send_byte({7'h31, 1'b1}, -1, 0, a1);
      do_start();
      do_stop();
      chk("R2 ack pd1", a1, 1);
      chk("R4 shutdown kept", shutdown, 0);
      chk("R4 no strobe rstart", upd_cnt - u0, 0);

      // R6: shutdown request, master reads byte
      u0 = upd_cnt;
      do_start();
      send_byte({7'h31, 1'b1}, -1, 0, a1);
      read_byte(rv, nine);
      do_stop();
      chk("R6 addr ack", a1, 1);
      chk("R6 read ones", rv, 'hFF);
      chk("R6 ninth released", nine, 1);
      chk("R6 shutdown set", shutdown, 1);
      chk("R6 code kept", dac_code, 255);
      chk("R6 strobe", upd_cnt - u0, 1);

      // R5: wake with new code
      write_tx(7'h31, 8'h15, a1, a2);
      chk("R5 wake shutdown", shutdown, 0);
      chk("R5 wake code", dac_code, 'h15);

      // R7: repeated START after data discards, next transfer commits
      u0 = upd_cnt;
      do_start();
      send_byte({7'h31, 1'b0}, -1, 0, a1);
      send_byte(8'h2A, -1, 0, a2);
      do_start();
      send_byte({7'h31, 1'b0}, -1, 0, a1);
      send_byte(8'h07, -1, 0, a2);
      do_stop();
      chk("R7 second commit", dac_code, 'h07);
      chk("R7 one strobe", upd_cnt - u0, 1);
      u0 = upd_cnt;
      do_start();
      send_byte({7'h31, 1'b0}, -1, 0, a1);
      send_byte(8'h2A, -1, 0, a2);
      do_start();
      do_stop();
      chk("R7 discarded code", dac_code, 'h07);
      chk("R7 no strobe", upd_cnt - u0, 0);

      // R8: third byte
      u0 = upd_cnt;
      do_start();
      send_byte({7'h31, 1'b0}, -1, 0, a1);
      send_byte(8'h11, -1, 0, a2);
      send_byte(8'h22, -1, 0, nine);
      do_stop();
      chk("R8 third not acked", nine, 0);
      chk("R8 code kept", dac_code, 'h07);
      chk("R8 no strobe", upd_cnt - u0, 0);

      // R9: short SCL pulse and short SDA pulse
      do_start();
      send_byte({7'h31, 1'b0}, -1, 0, a1);
      send_byte(8'h3C, 4, 1, a2);
      do_stop();
      chk("R9 scl glitch code", dac_code, 'h3C);
      do_start();
      send_byte({7'h31, 1'b0}, -1, 0, a1);
      send_byte(8'hA5, 5, 2, a2);
      do_stop();
      chk("R9 sda glitch ack", a2, 1);
      chk("R9 sda glitch code", dac_code, 'hA5);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule